// File: doc/BRIEF.md
# PCM Companding Law Translator

This block rewrites one 8-bit PCM sample per cycle from one coding law into another. Each sample arrives with its own control word. A mode flag picks voice or data handling, and two 2-bit codes name the law of the incoming byte and the law wanted at the output. The translated byte leaves through one register stage, with a valid strobe one cycle after the input strobe. The block sits in the output path of a time-slot switch and treats switched-connection traffic and message traffic in the same way.

In voice mode the block handles the two standard companding laws and two non-standard variants. The first variant is A-law whose even bits are left unflipped. The second is µ-law whose seven magnitude bits are left uncomplemented. A variant is first folded onto its standard law. When the two laws belong to different families, the sample is expanded to signed linear form and compressed into the other family. The result is then unfolded into the requested output variant.

In data mode each code stands for an inversion mask. The input mask is removed to recover the raw byte, and then the output mask is applied.

Top module: `pcm_law_xlat`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `out_valid` is 0 and `out_byte` is 8'h00.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock. `out_byte` updates only in the cycle after `in_valid` was 1, and otherwise holds its last value.
- R3: With `is_data`=1, the code values 0, 1, 2 and 3 select the masks 8'h00, 8'h55, 8'hAA and 8'hFF. The output is the input byte XOR mask(in_code) XOR mask(out_code).
- R4: When `in_code` equals `out_code`, in either mode, the output byte equals the input byte.
- R5: With `is_data`=0, the code values are: 0 is standard A-law, 1 is standard µ-law, 2 is A-law without even-bit inversion, and 3 is µ-law without magnitude inversion. Code 2 equals the code 0 byte XOR 8'h55. Code 3 equals the code 1 byte XOR 8'h7F.
- R6: For voice translation inside one family (codes 0 and 2, or codes 1 and 3), the output is the input XOR 8'h55 for A-law or XOR 8'h7F for µ-law.
- R7: For voice translation from A-law to µ-law, the standard A-law byte is decoded to 16-bit linear form. That value is floor-shifted right by 2, its magnitude is clipped to 8159, 33 is added, and it is encoded as standard µ-law. A sum above 8191 gives the maximum code for its sign.
- R8: For voice translation from µ-law to A-law, the standard µ-law byte is decoded to 16-bit linear form and floor-shifted right by 3. A non-negative value p is encoded from p; a negative value is encoded from -p-1. It is encoded as standard A-law, and a value above 4095 gives the maximum code for its sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_byte | input | 8 | Input PCM sample |
| is_data | input | 1 | 0 = voice codes, 1 = data codes |
| in_code | input | 2 | Coding law of the input sample |
| out_code | input | 2 | Coding law wanted at the output |
| out_valid | output | 1 | Output sample strobe |
| out_byte | output | 8 | Translated sample |

## Verification
Both cross-family directions are swept over all 256 input bytes. This exposes the segment edges, the zero codes and the clipped extremes:
- A wrong segment threshold or rounding step would move a whole band of outputs by one code.
- A broken clip would wrap the largest magnitudes to small codes.

Every pairing of the four codes is run at the bytes 8'h00, 8'h7F, 8'h80 and 8'hFF in both modes. A design that swapped the variant masks, or applied a data mask in the wrong direction, would corrupt the outputs at those bytes. Idle gaps are mixed at random into the traffic. A design that updated the byte without a strobe, or slipped the strobe, would show a changed or mistimed output.

// File: rtl/pcm_xlat_pkg.sv
package pcm_xlat_pkg;

    localparam int SAMPLE_W = 8;
    localparam int LIN_W    = 16;

    typedef enum logic [1:0] {
        LAW_A     = 2'd0,
        LAW_U     = 2'd1,
        LAW_A_ALT = 2'd2,
        LAW_U_ALT = 2'd3
    } voice_law_e;

    typedef struct packed {
        logic                valid;
        logic [SAMPLE_W-1:0] data;
    } xlat_state_t;

    // Mask that folds a voice variant onto its standard law (self-inverse)
    function automatic logic [SAMPLE_W-1:0] variant_mask(input logic [1:0] code);
        case (code)
            LAW_A_ALT: variant_mask = 8'h55;
            LAW_U_ALT: variant_mask = 8'h7F;
            default:   variant_mask = 8'h00;
        endcase
    endfunction

    // Inversion mask of a data-mode code
    function automatic logic [SAMPLE_W-1:0] data_mask(input logic [1:0] code);
        case (code)
            2'd1:    data_mask = 8'h55;
            2'd2:    data_mask = 8'hAA;
            2'd3:    data_mask = 8'hFF;
            default: data_mask = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/pcm_expand.sv
module pcm_expand
    import pcm_xlat_pkg::*;
#(
    parameter bit ULAW = 1'b0
) (
    input  logic [SAMPLE_W-1:0]     code,
    output logic signed [LIN_W-1:0] lin
);
    localparam logic [LIN_W-1:0] U_BIAS = 16'h0084;

    generate
        if (ULAW) begin : g_ulaw
            logic [7:0]       inv;
            logic [LIN_W-1:0] t;
            always_comb begin
                inv = ~code;
                t   = ({12'd0, inv[3:0]} << 3) + U_BIAS;
                t   = t << inv[6:4];
                lin = inv[7] ? signed'(U_BIAS - t) : signed'(t - U_BIAS);
            end
        end else begin : g_alaw
            logic [7:0]       raw;
            logic [LIN_W-1:0] t;
            always_comb begin
                raw = code ^ 8'h55;
                t   = {12'd0, raw[3:0]} << 4;
                if (raw[6:4] == 3'd0) begin
                    t = t + 16'd8;
                end else begin
                    t = (t + 16'h0108) << (raw[6:4] - 3'd1);
                end
                lin = raw[7] ? signed'(t) : signed'(16'd0 - t);
            end
        end
    endgenerate

endmodule

// File: rtl/pcm_compress.sv
module pcm_compress
    import pcm_xlat_pkg::*;
#(
    parameter bit ULAW = 1'b0
) (
    input  logic signed [LIN_W-1:0] lin,
    output logic [SAMPLE_W-1:0]     code
);
    localparam int NSEG = 8;

    generate
        if (ULAW) begin : g_ulaw
            logic signed [LIN_W-1:0] p;
            logic [LIN_W-1:0]        mag;
            logic [LIN_W-1:0]        sh;
            logic [7:0]              mask;
            logic [3:0]              seg;
            always_comb begin
                p    = lin >>> 2;
                mask = p[LIN_W-1] ? 8'h7F : 8'hFF;
                mag  = p[LIN_W-1] ? 16'(-p) : 16'(p);
                if (mag > 16'd8159) mag = 16'd8159;
                mag  = mag + 16'd33;
                seg  = 4'(NSEG);
                for (int s = NSEG - 1; s >= 0; s--) begin
                    if (mag <= 16'((64 << s) - 1)) seg = 4'(s);
                end
                sh   = mag >> (seg + 4'd1);
                if (seg == 4'(NSEG)) code = 8'h7F ^ mask;
                else                 code = {1'b0, seg[2:0], sh[3:0]} ^ mask;
            end
        end else begin : g_alaw
            logic signed [LIN_W-1:0] p;
            logic [LIN_W-1:0]        mag;
            logic [LIN_W-1:0]        sh;
            logic [7:0]              mask;
            logic [3:0]              seg;
            always_comb begin
                p    = lin >>> 3;
                mask = p[LIN_W-1] ? 8'h55 : 8'hD5;
                mag  = p[LIN_W-1] ? 16'(-p - 16'sd1) : 16'(p);
                seg  = 4'(NSEG);
                for (int s = NSEG - 1; s >= 0; s--) begin
                    if (mag <= 16'((32 << s) - 1)) seg = 4'(s);
                end
                sh   = (seg < 4'd2) ? (mag >> 1) : (mag >> seg);
                if (seg == 4'(NSEG)) code = 8'h7F ^ mask;
                else                 code = {1'b0, seg[2:0], sh[3:0]} ^ mask;
            end
        end
    endgenerate

endmodule

// File: rtl/pcm_law_xlat.sv
module pcm_law_xlat
    import pcm_xlat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       is_data,
    input  logic [1:0] in_code,
    input  logic [1:0] out_code,
    output logic       out_valid,
    output logic [7:0] out_byte
);
    xlat_state_t st_d, st_q;

    logic [SAMPLE_W-1:0]     canon;
    logic signed [LIN_W-1:0] lin_from_a, lin_from_u;
    logic [SAMPLE_W-1:0]     u_from_a, a_from_u;
    logic [SAMPLE_W-1:0]     conv, voice_res, data_res;

    // Fold the input variant onto its standard law
    assign canon = in_byte ^ variant_mask(in_code);

    pcm_expand   #(.ULAW(1'b0)) u_exp_a  (.code(canon),      .lin(lin_from_a));
    pcm_compress #(.ULAW(1'b1)) u_cmp_u  (.lin(lin_from_a),  .code(u_from_a));
    pcm_expand   #(.ULAW(1'b1)) u_exp_u  (.code(canon),      .lin(lin_from_u));
    pcm_compress #(.ULAW(1'b0)) u_cmp_a  (.lin(lin_from_u),  .code(a_from_u));

    always_comb begin
        // code bit 0 names the family: 0 = A-law, 1 = mu-law
        if (in_code[0] == out_code[0]) conv = canon;
        else if (in_code[0])           conv = a_from_u;
        else                           conv = u_from_a;
        voice_res = conv ^ variant_mask(out_code);
        data_res  = in_byte ^ data_mask(in_code) ^ data_mask(out_code);

        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) st_d.data = is_data ? data_res : voice_res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_byte  = st_q.data;

    p_strobe_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_strobe_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_byte));
    p_same_code_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_code == out_code) |=> out_byte == $past(in_byte));
    p_data_full_inv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_data && in_code == 2'd0 && out_code == 2'd3)
        |=> out_byte == ~$past(in_byte));
    p_a_variant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_data && in_code == 2'd0 && out_code == 2'd2)
        |=> out_byte == ($past(in_byte) ^ 8'h55));

endmodule

// File: tb/tb_pcm_law_xlat.sv
module tb_pcm_law_xlat;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       is_data = 1'b0;
    logic [1:0] in_code = 2'd0;
    logic [1:0] out_code = 2'd0;
    logic       out_valid;
    logic [7:0] out_byte;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    bit         exp_valid = 0;
    logic [7:0] exp_byte = 8'h00;
    string      exp_tag = "R1";

    pcm_law_xlat dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int floor_div(int x, int d);
        return (x >= 0) ? x / d : -((-x + d - 1) / d);
    endfunction

    function automatic int lin_of_a(int c);
        int r, m, e, mag;
        r = (c ^ 'h55) & 255;
        m = r % 16;
        e = (r / 16) % 8;
        if (e == 0) mag = m * 16 + 8;
        else        mag = (m * 16 + 264) * (1 << (e - 1));
        return (r >= 128) ? mag : -mag;
    endfunction

    function automatic int lin_of_u(int c);
        int r, t;
        r = 255 - c;
        t = ((r % 16) * 8 + 132) * (1 << ((r / 16) % 8));
        return (r >= 128) ? 132 - t : t - 132;
    endfunction

    function automatic int u_of_lin(int x);
        int p, m, msk, seg;
        p = floor_div(x, 4);
        if (p < 0) begin msk = 'h7F; m = -p; end
        else       begin msk = 'hFF; m = p;  end
        if (m > 8159) m = 8159;
        m = m + 33;
        if (m > 8191) return 'h7F ^ msk;
        seg = 0;
        while (m > 64 * (1 << seg) - 1) seg++;
        return ((seg * 16) + ((m / (1 << (seg + 1))) % 16)) ^ msk;
    endfunction

    function automatic int a_of_lin(int x);
        int p, m, msk, seg;
        p = floor_div(x, 8);
        if (p < 0) begin msk = 'h55; m = -p - 1; end
        else       begin msk = 'hD5; m = p;      end
        if (m > 4095) return 'h7F ^ msk;
        seg = 0;
        while (m > 32 * (1 << seg) - 1) seg++;
        if (seg < 2) return ((seg * 16) + ((m / 2) % 16)) ^ msk;
        return ((seg * 16) + ((m / (1 << seg)) % 16)) ^ msk;
    endfunction

    function automatic int dmask(int c);
        return (c == 1) ? 'h55 : (c == 2) ? 'hAA : (c == 3) ? 'hFF : 0;
    endfunction

    function automatic int vmask(int c);
        return (c == 2) ? 'h55 : (c == 3) ? 'h7F : 0;
    endfunction

    function automatic int model(bit d, int ic, int oc, int b);
        int s, t;
        if (d) return b ^ dmask(ic) ^ dmask(oc);
        s = b ^ vmask(ic);
        if ((ic % 2) == (oc % 2)) t = s;
        else if (ic % 2 == 0)     t = u_of_lin(lin_of_a(s));
        else                      t = a_of_lin(lin_of_u(s));
        return t ^ vmask(oc);
    endfunction

    function automatic string tag_of(bit v, bit d, int ic, int oc);
        if (!v)                         return "R2";
        if (ic == oc)                   return "R4";
        if (d)                          return "R3";
        if ((ic % 2) == (oc % 2))       return "R6";
        if (ic >= 2 || oc >= 2)         return "R5";
        if (ic == 0)                    return "R7";
        return "R8";
    endfunction

    task automatic check_out();
        n_checks++;
        if (out_valid !== exp_valid || out_byte !== exp_byte) begin
            n_errors++;
            $display("FAIL %s: got valid=%0b byte=%02h, expected valid=%0b byte=%02h",
                     exp_tag, out_valid, out_byte, exp_valid, exp_byte);
        end
    endtask

    // One cycle: check the result of the previous drive, then drive anew
    task automatic step(bit v, bit d, int ic, int oc, int b);
        @(negedge clk);
        check_out();
        in_valid = v; is_data = d; in_code = 2'(ic); out_code = 2'(oc); in_byte = 8'(b);
        exp_valid = v;
        if (v) exp_byte = 8'(model(d, ic, oc, b));
        exp_tag = tag_of(v, d, ic, oc);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        // R1: reset state, driven inputs active during reset
        in_valid = 1'b1; in_byte = 8'h3C; is_data = 1'b1; in_code = 2'd3;
        repeat (3) begin
            @(negedge clk);
            exp_tag = "R1";
            check_out();
        end
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_tag = "R1"; exp_valid = 0; exp_byte = 8'h00;

        // R7/R8: exhaustive cross-family sweeps
        for (int b = 0; b < 256; b++) step(1, 0, 0, 1, b);
        for (int b = 0; b < 256; b++) step(1, 0, 1, 0, b);
        // R3/R4/R5/R6: every code pair at boundary bytes in both modes
        for (int d = 0; d < 2; d++)
            for (int ic = 0; ic < 4; ic++)
                for (int oc = 0; oc < 4; oc++)
                    for (int k = 0; k < 4; k++)
                        step(1, d[0], ic, oc, (k == 0) ? 'h00 : (k == 1) ? 'h7F : (k == 2) ? 'h80 : 'hFF);
        // R2: idle gap holds the byte
        step(1, 1, 0, 3, 'h12);
        step(0, 1, 0, 1, 'hEE);
        step(0, 0, 2, 1, 'h44);
        // Random traffic with idle gaps
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 4) != 0, $urandom % 2, $urandom % 4, $urandom % 4, $urandom % 256);
        end
        step(0, 0, 0, 0, 0);
        @(negedge clk);
        check_out();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule